// File: doc/BRIEF.md
# Unsigned Multiply-Divide Unit

A sequential arithmetic unit that works on an 8-bit register triple: a high byte Y, a low byte A and a divisor byte X. Y and A together form a 16-bit accumulator. In multiply mode the unit forms the unsigned product of Y and A and returns it across the Y:A pair. In divide mode it divides the unsigned 16-bit Y:A value by X. The quotient comes back in A and the remainder in Y.

The surrounding core pulses `start_i` with the operands and the operation select. It then waits for the one-cycle `done_o` pulse. Each operation has a fixed latency: 9 cycles for multiply and 12 for divide. A cycle count that depends on the data never reaches the core. The results and status flags are registered, and they hold their values until the next operation completes. A divisor of zero ends on time with a defined result.

Top module: `muldiv_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, y_o, a_o, n_o, v_o, h_o, z_o, busy_o and done_o are all 0.
- R2: With op_div_i = 0 (multiply), the result satisfies {y_o, a_o} = y_i * a_i as an unsigned 16-bit product, with the high byte in y_o.
- R3: After a multiply, n_o equals bit 15 of the product and z_o is 1 exactly when the high byte y_o is 0. v_o and h_o keep the values they had before.
- R4: With op_div_i = 1 (divide) and x_i != 0, a_o is the low 8 bits of floor({y_i,a_i} / x_i) and y_o is {y_i,a_i} mod x_i.
- R5: After a divide, n_o = a_o[7] and z_o = (a_o == 0). v_o = (y_i >= x_i), which means the true quotient does not fit in 8 bits. h_o = (x_i[3:0] <= y_i[3:0]).
- R6: A divide with x_i = 0 returns a_o = 8'hFF and y_o = y_i, and sets v_o to 1. It completes with the normal divide latency.
- R7: A start is accepted on a rising edge where start_i = 1 and busy_o = 0. busy_o is then high for the following LAT cycles. done_o pulses high for exactly one cycle after the LAT-th edge counted from the accepting edge, and busy_o is low during that cycle. LAT is 9 for multiply and 12 for divide.
- R8: When start_i is high while busy_o is high, it is ignored. The running operation's result, flags and latency stay unchanged, and no extra operation runs afterwards.
- R9: y_o, a_o and the flags change only on the edge that raises done_o. They stay stable while the unit is busy and while it is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (ignored while busy) |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| y_i | input | 8 | High byte of accumulator / multiplicand |
| a_i | input | 8 | Low byte of accumulator / multiplier |
| x_i | input | 8 | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| y_o | output | 8 | Product high byte or remainder |
| a_o | output | 8 | Product low byte or quotient |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Divide overflow flag |
| h_o | output | 1 | Divide nibble-compare flag |
| z_o | output | 1 | Zero flag |

## Verification
The bench builds the unit with its default parameters: 8-bit operands, latencies of 9 and 12, and two quotient bits per divide cycle. With these values every divide overflow case is reachable from the vector table: wrapped quotients, the maximum dividend over 0xFF, and a zero divisor. Multiply results with a zero high byte but a non-zero low byte are also reachable, which separates the zero flag from the low byte. Because the latencies exceed the iteration counts, the idle padding cycles are exercised as well. A start that arrives during those cycles must still be ignored.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } op_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int MUL_LAT   = 9,
  parameter int DIV_LAT   = 12,
  parameter int MUL_STEPS = 8,
  parameter int DIV_STEPS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic step_o,
  output logic commit_o,
  output op_e  op_o
);
  localparam int MAX_LAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
  localparam int CW = $clog2(MAX_LAT + 1);
  localparam logic [CW-1:0] MUL_LAST = CW'(MUL_LAT - 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_LAT - 1);
  localparam logic [CW-1:0] MUL_NSTP = CW'(MUL_STEPS);
  localparam logic [CW-1:0] DIV_NSTP = CW'(DIV_STEPS);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  op_e           op_q;
  logic [CW-1:0] last_cnt, n_steps;

  assign last_cnt = (op_q == OP_DIV) ? DIV_LAST : MUL_LAST;
  assign n_steps  = (op_q == OP_DIV) ? DIV_NSTP : MUL_NSTP;
  assign load_o   = start_i && !busy_q;
  assign step_o   = busy_q && (cnt_q < n_steps);
  assign commit_o = busy_q && (cnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_MUL;
    end else begin
      done_q <= commit_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        op_q   <= op_i;
      end else if (busy_q) begin
        if (commit_o) busy_q <= 1'b0;
        else          cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign op_o   = op_q;
endmodule

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0] hi_q, lo_q, mcand_q;
  logic [W:0]   sum;

  // shift-add, multiplier bits consumed LSB first
  assign sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      hi_q    <= '0;
      lo_q    <= mplier_i;
      mcand_q <= mcand_i;
    end else if (step_i) begin
      {hi_q, lo_q} <= {sum, lo_q[W-1:1]};
    end
  end

  assign prod_o = {hi_q, lo_q};
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int W  = 8,
  parameter int RB = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o
);
  logic [W-1:0]   rem_q, dvs_q;
  logic [2*W-1:0] quo_q;
  logic [W-1:0]   rem_c;
  logic [2*W-1:0] quo_c;
  logic [W:0]     trial;

  // RB restoring steps per cycle; quo_q shifts dividend out, quotient in
  always_comb begin
    rem_c = rem_q;
    quo_c = quo_q;
    trial = '0;
    for (int k = 0; k < RB; k++) begin
      trial = {rem_c, quo_c[2*W-1]};
      quo_c = {quo_c[2*W-2:0], 1'b0};
      if (trial >= {1'b0, dvs_q}) begin
        trial    = trial - {1'b0, dvs_q};
        quo_c[0] = 1'b1;
      end
      rem_c = trial[W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dividend_i;
      dvs_q <= divisor_i;
    end else if (step_i) begin
      rem_q <= rem_c;
      quo_q <= quo_c;
    end
  end

  assign quo_o = quo_q[W-1:0];
  assign rem_o = rem_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W         = 8,
  parameter int MUL_LAT   = 9,
  parameter int DIV_LAT   = 12,
  parameter int DIV_RADIX = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         op_div_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] x_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] a_o,
  output logic         n_o,
  output logic         v_o,
  output logic         h_o,
  output logic         z_o
);
  localparam int MUL_STEPS = W;
  localparam int DIV_STEPS = (2 * W) / DIV_RADIX;

  logic           load, step, commit;
  op_e            op_q;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, rem;

  muldiv_ctrl #(
    .MUL_LAT  (MUL_LAT),
    .DIV_LAT  (DIV_LAT),
    .MUL_STEPS(MUL_STEPS),
    .DIV_STEPS(DIV_STEPS)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_e'(op_div_i)),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load),
    .step_o  (step),
    .commit_o(commit),
    .op_o    (op_q)
  );

  muldiv_mul #(.W(W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step && (op_q == OP_MUL)),
    .mcand_i (y_i),
    .mplier_i(a_i),
    .prod_o  (prod)
  );

  muldiv_div #(.W(W), .RB(DIV_RADIX)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step && (op_q == OP_DIV)),
    .dividend_i({y_i, a_i}),
    .divisor_i (x_i),
    .quo_o     (quo),
    .rem_o     (rem)
  );

  // divide flags depend only on the operands; capture them at start
  logic         ovf_q, hc_q, zdiv_q;
  logic [W-1:0] yin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      hc_q   <= 1'b0;
      zdiv_q <= 1'b0;
      yin_q  <= '0;
    end else if (load) begin
      ovf_q  <= (y_i >= x_i);
      hc_q   <= (x_i[3:0] <= y_i[3:0]);
      zdiv_q <= (x_i == '0);
      yin_q  <= y_i;
    end
  end

  logic [W-1:0] y_res, a_res;

  always_comb begin
    if (op_q == OP_DIV) begin
      a_res = zdiv_q ? '1 : quo;
      y_res = zdiv_q ? yin_q : rem;
    end else begin
      a_res = prod[W-1:0];
      y_res = prod[2*W-1:W];
    end
  end

  logic [W-1:0] y_q, a_q;
  logic         n_q, v_q, h_q, z_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q <= '0;
      a_q <= '0;
      n_q <= 1'b0;
      v_q <= 1'b0;
      h_q <= 1'b0;
      z_q <= 1'b0;
    end else if (commit) begin
      y_q <= y_res;
      a_q <= a_res;
      if (op_q == OP_DIV) begin
        n_q <= a_res[W-1];
        z_q <= (a_res == '0);
        v_q <= ovf_q;
        h_q <= hc_q;
      end else begin
        n_q <= y_res[W-1];
        z_q <= (y_res == '0);
      end
    end
  end

  assign y_o = y_q;
  assign a_o = a_q;
  assign n_o = n_q;
  assign v_o = v_q;
  assign h_o = h_q;
  assign z_o = z_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W       = 8,
  parameter int MUL_LAT = 9,
  parameter int DIV_LAT = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         op_div_i,
  input logic [W-1:0] y_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] x_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] y_o,
  input logic [W-1:0] a_o,
  input logic         n_o,
  input logic         v_o,
  input logic         h_o,
  input logic         z_o
);
  logic         active, cap_op;
  logic [W-1:0] cap_y, cap_a, cap_x;
  int unsigned  cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      cap_op <= 1'b0;
      cap_y  <= '0;
      cap_a  <= '0;
      cap_x  <= '0;
      cyc    <= 0;
    end else if (start_i && !busy_o) begin
      active <= 1'b1;
      cap_op <= op_div_i;
      cap_y  <= y_i;
      cap_a  <= a_i;
      cap_x  <= x_i;
      cyc    <= 0;
    end else if (active) begin
      if (done_o) active <= 1'b0;
      cyc <= cyc + 1;
    end
  end

  // R7
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7 R8
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (active && cyc == (cap_op ? DIV_LAT : MUL_LAT)));
  // R2
  mul_product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cap_op) |-> ({y_o, a_o} == ((2*W)'(cap_y) * (2*W)'(cap_a))));
  // R3
  mul_keeps_vh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cap_op) |-> ($stable(v_o) && $stable(h_o)));
  // R5
  div_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_op) |-> (v_o == (cap_y >= cap_x)));
  // R5
  div_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_op) |-> (n_o == a_o[W-1] && z_o == (a_o == '0)));
  // R6
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_op && cap_x == '0) |-> (a_o == '1 && y_o == cap_y));
  // R9
  hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($stable(a_o) && $stable(y_o) && $stable(h_o)));
endmodule

bind muldiv_unit muldiv_unit_chk #(
  .W      (W),
  .MUL_LAT(MUL_LAT),
  .DIV_LAT(DIV_LAT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_div_i(op_div_i),
  .y_i     (y_i),
  .a_i     (a_i),
  .x_i     (x_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .y_o     (y_o),
  .a_o     (a_o),
  .n_o     (n_o),
  .v_o     (v_o),
  .h_o     (h_o),
  .z_o     (z_o)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  localparam int MUL_LAT = 9;
  localparam int DIV_LAT = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       op_div_i = 1'b0;
  logic [7:0] y_i = '0, a_i = '0, x_i = '0;
  logic       busy_o, done_o, n_o, v_o, h_o, z_o;
  logic [7:0] y_o, a_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  muldiv_unit dut (
    .clk_i, .rst_ni, .start_i, .op_div_i, .y_i, .a_i, .x_i,
    .busy_o, .done_o, .y_o, .a_o, .n_o, .v_o, .h_o, .z_o
  );

  typedef struct packed {
    logic       op;
    logic [7:0] y, a, x, ey, ea;
    logic       en, ev, eh, ez;
  } vec_t;

  // multiplies first: V/H stay at their reset value 0
  localparam vec_t VEC [12] = '{
    '{1'b0, 8'h12, 8'h34, 8'h00, 8'h03, 8'hA8, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'hFF, 8'hFF, 8'h00, 8'hFE, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 8'h77, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'h10, 8'h0F, 8'h00, 8'h00, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 8'h12, 8'h34, 8'h56, 8'h10, 8'h36, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'h0A, 8'h05, 8'h0B, 8'h02, 8'hE9, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'h00, 8'h05, 8'h07, 8'h05, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 8'h20, 8'h00, 8'h10, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b1, 8'h12, 8'h34, 8'h03, 8'h01, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h3C, 8'h99, 8'h00, 8'h3C, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b1, 8'h00, 8'hFE, 8'hFF, 8'hFE, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // runs one op; returns edges from accept to done; poke = start during busy
  task automatic run_op(input logic op, input logic [7:0] y, input logic [7:0] a,
                        input logic [7:0] x, input bit poke,
                        output int lat, output bit hold_ok, output bit busy_ok);
    logic [7:0] py, pa;
    py = y_o;
    pa = a_o;
    hold_ok = 1'b1;
    @(negedge clk_i);
    op_div_i = op; y_i = y; a_i = a; x_i = x; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    busy_ok = busy_o && !done_o;
    lat = 0;
    while (lat < 200) begin
      if (busy_o && (y_o !== py || a_o !== pa)) hold_ok = 1'b0;
      if (poke && lat == 3) begin
        start_i = 1'b1; op_div_i = 1'b0; y_i = 8'hFF; a_i = 8'hFF; x_i = 8'h01;
      end else begin
        start_i = 1'b0;
      end
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      if (done_o) break;
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int  lat;
    bit  hold_ok, busy_ok;
    int  extra;
    string tr, tf;

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 reset outputs",
          {16'h0, y_o, a_o} | {28'h0, n_o, v_o, h_o, z_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 busy/done after release", {30'h0, busy_o, done_o}, 32'h0);

    foreach (VEC[i]) begin
      vec_t v;
      v = VEC[i];
      tr = v.op ? ((v.x == 0) ? "R6" : "R4") : "R2";
      tf = v.op ? ((v.x == 0) ? "R6" : "R5") : "R3";
      run_op(v.op, v.y, v.a, v.x, 1'b0, lat, hold_ok, busy_ok);
      check("R7 latency", lat, v.op ? DIV_LAT : MUL_LAT);
      check("R7 busy after accept", {31'h0, busy_ok}, 32'h1);
      check({tr, " result"}, {16'h0, y_o, a_o}, {16'h0, v.ey, v.ea});
      check({tf, " flags NVHZ"}, {28'h0, n_o, v_o, h_o, z_o},
            {28'h0, v.en, v.ev, v.eh, v.ez});
      check("R9 hold while busy", {31'h0, hold_ok}, 32'h1);
    end

    // R3: multiply after a divide that set V and H keeps them
    run_op(1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0, lat, hold_ok, busy_ok);
    check("R5 setup V/H", {30'h0, v_o, h_o}, 32'h3);
    run_op(1'b0, 8'h05, 8'h03, 8'h00, 1'b0, lat, hold_ok, busy_ok);
    check("R3 mul result", {16'h0, y_o, a_o}, 32'h000F);
    check("R3 mul keeps V/H, N=0 Z=1", {28'h0, n_o, v_o, h_o, z_o}, 32'h7);

    // R8: start during busy is ignored
    run_op(1'b1, 8'h12, 8'h34, 8'h56, 1'b1, lat, hold_ok, busy_ok);
    check("R8 latency unchanged", lat, DIV_LAT);
    check("R8 result of first op", {16'h0, y_o, a_o}, 32'h1036);
    extra = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (done_o || busy_o) extra++;
    end
    check("R8 no queued op", extra, 0);

    // R9: idle hold with changing inputs
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      op_div_i = k[0]; y_i = 8'(k * 37); a_i = 8'(k * 11); x_i = 8'(k);
    end
    @(negedge clk_i);
    check("R9 idle hold", {16'h0, y_o, a_o}, 32'h1036);

    // R1: reset in the middle of an operation
    @(negedge clk_i);
    op_div_i = 1'b0; y_i = 8'hFF; a_i = 8'hFF; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid-op reset", {14'h0, y_o, a_o, busy_o, done_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (12) @(negedge clk_i);
    check("R1 no done after reset", {31'h0, done_o}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule